// File: doc/BRIEF.md
# Periodic Ripple Subtraction Unit

This block cleans mains-synchronous ripple out of a decimated, already filtered sample stream that is shared by four channels. For every channel it records one ripple period into one of two waveform pages, sums the same period to get that page's mean, and checks from one period to the next whether the signal repeats. Once a page has passed that check, it becomes the channel's template. Each later sample then has the template's deviation from its own mean taken away: the output is the sample minus the difference between the stored value and the mean. The ripple is removed and the DC level and slow drifts are kept.

The period length is programmed as a power of two through a log2 input. The repetition tolerance is a programmable magnitude. Samples from different channels may arrive interleaved in any order, and idle cycles are allowed. Each result leaves one clock after its sample, tagged with the channel, the page being filled and whether a template was applied.

Top module: `ripple_cancel`

## Requirements
- R1: While `rst` is high, and on the first cycle after it, `out_valid` is 0. Reset clears every channel: phase 0, fill page 0, no template, no samples from a previous period.
- R2: A sample accepted with `in_valid`=1 produces `out_valid`=1 on the next clock, with `out_chan` equal to its `in_chan`. A cycle with `in_valid`=0 produces `out_valid`=0 on the next clock.
- R3: While a channel has no template, `out_tpl`=0 and `out_sample` equals the input sample, sign-extended to 18 bits.
- R4: Each channel has a phase that starts at 0 and advances by one only on that channel's samples. It wraps after L−1, with L = 2^min(`period_log2`, 4). The phase selects the page slot that is written and read.
- R5: A sample on one channel leaves the phase, pages, means, flags and template of every other channel unchanged.
- R6: Each period is judged on its last sample. The first period written into a fresh page only primes that page. In a later period, if every sample is within the limit of the value stored at the same phase one period earlier, the page becomes the template. Its mean is set to floor(sum of that period / L). Filling then moves to the other page, which starts out fresh.
- R7: If every sample of a judged period is outside the limit, the template is dropped and filling moves to the other page, which starts out fresh.
- R8: If a judged period has some samples within the limit and some outside, the template, the fill page and the primed state are all left unchanged.
- R9: While a template is held, `out_sample` = y − (template[phase] − template mean), computed without overflow in 18 bits. `out_tpl`=1.
- R10: `out_page` is the fill page of the channel when the sample arrived, before any switch that sample causes. The template page is never the fill page.
- R11: A sample is outside the limit only when |y − stored| is strictly greater than `max_dy`. A difference equal to the limit counts as within it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | A sample is present this cycle |
| in_chan | input | 2 | Channel of the sample |
| in_sample | input | 16 | Filtered sample, two's complement |
| period_log2 | input | 3 | log2 of the period length, clamped to 4 |
| max_dy | input | 16 | Repetition tolerance, unsigned |
| out_valid | output | 1 | A result is present this cycle |
| out_chan | output | 2 | Channel of the result |
| out_sample | output | 18 | De-rippled sample, two's complement |
| out_page | output | 1 | Page that was being filled |
| out_tpl | output | 1 | A template was subtracted |

## Verification
A periodic waveform with small noise on top shows adoption, subtraction and the alternation between pages. A step in DC in the middle of the stream makes every sample of a period fail, so the template is dropped and relearned. Random data keeps a channel dropping and passing samples straight through. A pattern that fails at only one phase gives mixed periods that must change nothing. A constant input checks that the mean cancels exactly. Runs with a 16-sample period at a tolerance equal to the period-to-period difference, and with a one-sample period, test the strict limit, the clamping of the period setting and the wrap at both extremes, all while the four channels are interleaved with idle cycles.

// File: rtl/ripple_cancel_pkg.sv
package ripple_cancel_pkg;

    localparam int SMP_W  = 16;                 // sample width
    localparam int LG_MAX = 4;                  // largest log2 period
    localparam int CH_N   = 4;                  // channels served
    localparam int CH_W   = $clog2(CH_N);
    localparam int LG_W   = $clog2(LG_MAX + 1);
    localparam int PH_W   = LG_MAX;
    localparam int L_MAX  = 1 << LG_MAX;
    localparam int ACC_W  = SMP_W + LG_MAX;
    localparam int OUT_W  = SMP_W + 2;

    typedef logic signed [SMP_W-1:0] smp_t;
    typedef logic signed [ACC_W-1:0] acc_t;
    typedef logic signed [OUT_W-1:0] out_t;
    typedef logic [PH_W-1:0]         ph_t;

    // per-channel learning state
    typedef struct packed {
        ph_t  phase;
        logic fill_pg;
        logic primed;
        logic tpl_ok;
        logic tpl_pg;
        logic seen_ok;
        logic seen_bad;
        acc_t acc;
    } chan_ctl_t;

    typedef enum logic [1:0] {
        VD_KEEP,
        VD_PRIME,
        VD_ADOPT,
        VD_DROP
    } verdict_e;

    function automatic logic [LG_W-1:0] clamp_lg(input logic [LG_W-1:0] lg);
        return (lg > LG_W'(LG_MAX)) ? LG_W'(LG_MAX) : lg;
    endfunction

    function automatic logic over_limit(input smp_t a, input smp_t b,
                                        input logic [SMP_W-1:0] lim);
        logic signed [SMP_W:0] diff;
        logic [SMP_W:0]        mag;
        diff = {a[SMP_W-1], a} - {b[SMP_W-1], b};
        mag  = diff[SMP_W] ? (SMP_W+1)'(-diff) : (SMP_W+1)'(diff);
        return mag > {1'b0, lim};
    endfunction

endpackage

// File: rtl/ripple_cancel_store.sv
module ripple_cancel_store
    import ripple_cancel_pkg::*;
(
    input  logic            clk,
    input  logic            wr_en,
    input  logic [CH_W-1:0] chan,
    input  ph_t             ph,
    input  logic            wr_pg,
    input  smp_t            wr_data,
    input  logic            rd_pg,
    output smp_t            fill_word,
    output smp_t            tpl_word
);
    localparam int IDX_W = CH_W + 1 + PH_W;
    localparam int DEPTH = 1 << IDX_W;

    smp_t mem [DEPTH];

    logic [IDX_W-1:0] wr_idx, rd_idx;
    assign wr_idx = {chan, wr_pg, ph};
    assign rd_idx = {chan, rd_pg, ph};

    // previous-period value of the page being filled, and template value
    assign fill_word = mem[wr_idx];
    assign tpl_word  = mem[rd_idx];

    always_ff @(posedge clk) begin
        if (wr_en) mem[wr_idx] <= wr_data;
    end

endmodule

// File: rtl/ripple_cancel_judge.sv
module ripple_cancel_judge
    import ripple_cancel_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic [CH_W-1:0]  in_chan,
    input  smp_t             in_sample,
    input  logic [LG_W-1:0]  lg,
    input  logic [SMP_W-1:0] max_dy,
    input  smp_t             fill_word,
    output chan_ctl_t        cur_ctl,
    output smp_t             cur_mean
);
    chan_ctl_t ctl_q  [CH_N];
    smp_t      mean_q [CH_N][2];

    assign cur_ctl  = ctl_q[in_chan];
    assign cur_mean = mean_q[in_chan][cur_ctl.tpl_pg];

    ph_t       last_ph;
    logic      period_end, bad, any_ok, any_bad;
    acc_t      total;
    smp_t      mean_new;
    verdict_e  verdict;
    chan_ctl_t nxt;

    always_comb begin
        last_ph    = ph_t'((32'd1 << lg) - 32'd1);
        period_end = cur_ctl.phase >= last_ph;
        bad        = over_limit(in_sample, fill_word, max_dy);
        any_ok     = cur_ctl.seen_ok | ~bad;
        any_bad    = cur_ctl.seen_bad | bad;
        total      = cur_ctl.acc + acc_t'(in_sample);
        mean_new   = smp_t'(total >>> lg);

        if (!cur_ctl.primed)  verdict = VD_PRIME;
        else if (!any_bad)    verdict = VD_ADOPT;
        else if (!any_ok)     verdict = VD_DROP;
        else                  verdict = VD_KEEP;

        nxt = cur_ctl;
        if (!period_end) begin
            nxt.phase    = cur_ctl.phase + ph_t'(1);
            nxt.acc      = total;
            nxt.seen_ok  = any_ok;
            nxt.seen_bad = any_bad;
        end else begin
            nxt.phase    = '0;
            nxt.acc      = '0;
            nxt.seen_ok  = 1'b0;
            nxt.seen_bad = 1'b0;
            unique case (verdict)
                VD_PRIME: nxt.primed = 1'b1;
                VD_ADOPT: begin
                    nxt.tpl_ok  = 1'b1;
                    nxt.tpl_pg  = cur_ctl.fill_pg;
                    nxt.fill_pg = ~cur_ctl.fill_pg;
                    nxt.primed  = 1'b0;
                end
                VD_DROP: begin
                    nxt.tpl_ok  = 1'b0;
                    nxt.fill_pg = ~cur_ctl.fill_pg;
                    nxt.primed  = 1'b0;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int c = 0; c < CH_N; c++) begin
                ctl_q[c]     <= '0;
                mean_q[c][0] <= '0;
                mean_q[c][1] <= '0;
            end
        end else if (in_valid) begin
            ctl_q[in_chan] <= nxt;
            if (period_end && verdict == VD_ADOPT)
                mean_q[in_chan][cur_ctl.fill_pg] <= mean_new;
        end
    end

    for (genvar c = 0; c < CH_N; c++) begin : g_chk
        // R10: the template page is never the page being written
        a_r10_tpl_not_fill: assert property (@(posedge clk) disable iff (rst)
            ctl_q[c].tpl_ok |-> ctl_q[c].tpl_pg != ctl_q[c].fill_pg);
        // R6: adopting a template moves filling to the other page
        a_r6_adopt_flips: assert property (@(posedge clk) disable iff (rst)
            $rose(ctl_q[c].tpl_ok) |-> ctl_q[c].fill_pg != $past(ctl_q[c].fill_pg));
        // R5: state of a channel not addressed stays put
        a_r5_other_stable: assert property (@(posedge clk) disable iff (rst)
            (!in_valid || in_chan != CH_W'(c)) |=> $stable(ctl_q[c]));
    end

endmodule

// File: rtl/ripple_cancel_out.sv
module ripple_cancel_out
    import ripple_cancel_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            in_valid,
    input  logic [CH_W-1:0] in_chan,
    input  smp_t            in_sample,
    input  logic            tpl_ok,
    input  smp_t            tpl_word,
    input  smp_t            tpl_mean,
    input  logic            fill_pg,
    output logic            out_valid,
    output logic [CH_W-1:0] out_chan,
    output out_t            out_sample,
    output logic            out_page,
    output logic            out_tpl
);
    out_t corrected;
    assign corrected = out_t'(in_sample) - (out_t'(tpl_word) - out_t'(tpl_mean));

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid  <= 1'b0;
            out_chan   <= '0;
            out_sample <= '0;
            out_page   <= 1'b0;
            out_tpl    <= 1'b0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                out_chan   <= in_chan;
                out_sample <= tpl_ok ? corrected : out_t'(in_sample);
                out_page   <= fill_pg;
                out_tpl    <= tpl_ok;
            end
        end
    end

    // R1: no result right after reset
    a_r1_quiet_after_reset: assert property (@(posedge clk)
        rst |=> !out_valid);
    // R2: one result per accepted sample, one cycle later
    a_r2_valid_follows: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);
    a_r2_no_spurious: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);
    a_r2_chan_echo: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_chan == $past(in_chan));
    // R3: without a template the sample passes unchanged
    a_r3_passthrough: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !tpl_ok) |=> out_sample == out_t'($past(in_sample)));

endmodule

// File: rtl/ripple_cancel.sv
module ripple_cancel
    import ripple_cancel_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  in_valid,
    input  logic [1:0]            in_chan,
    input  logic signed [15:0]    in_sample,
    input  logic [2:0]            period_log2,
    input  logic [15:0]           max_dy,
    output logic                  out_valid,
    output logic [1:0]            out_chan,
    output logic signed [17:0]    out_sample,
    output logic                  out_page,
    output logic                  out_tpl
);
    logic [LG_W-1:0] lg_eff;
    chan_ctl_t       cur_ctl;
    smp_t            cur_mean, fill_word, tpl_word;

    assign lg_eff = clamp_lg(period_log2);

    ripple_cancel_store u_store (
        .clk       (clk),
        .wr_en     (in_valid),
        .chan      (in_chan),
        .ph        (cur_ctl.phase),
        .wr_pg     (cur_ctl.fill_pg),
        .wr_data   (in_sample),
        .rd_pg     (cur_ctl.tpl_pg),
        .fill_word (fill_word),
        .tpl_word  (tpl_word)
    );

    ripple_cancel_judge u_judge (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .in_chan   (in_chan),
        .in_sample (in_sample),
        .lg        (lg_eff),
        .max_dy    (max_dy),
        .fill_word (fill_word),
        .cur_ctl   (cur_ctl),
        .cur_mean  (cur_mean)
    );

    ripple_cancel_out u_out (
        .clk        (clk),
        .rst        (rst),
        .in_valid   (in_valid),
        .in_chan    (in_chan),
        .in_sample  (in_sample),
        .tpl_ok     (cur_ctl.tpl_ok),
        .tpl_word   (tpl_word),
        .tpl_mean   (cur_mean),
        .fill_pg    (cur_ctl.fill_pg),
        .out_valid  (out_valid),
        .out_chan   (out_chan),
        .out_sample (out_sample),
        .out_page   (out_page),
        .out_tpl    (out_tpl)
    );

endmodule

// File: tb/ripple_cancel_tb.sv
module ripple_cancel_tb;

    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic               in_valid = 1'b0;
    logic [1:0]         in_chan = '0;
    logic signed [15:0] in_sample = '0;
    logic [2:0]         period_log2 = 3'd2;
    logic [15:0]        max_dy = 16'd20;
    logic               out_valid, out_page, out_tpl;
    logic [1:0]         out_chan;
    logic signed [17:0] out_sample;

    always #10 clk = ~clk;   // 50 MHz

    ripple_cancel u_dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_chan(in_chan),
        .in_sample(in_sample), .period_log2(period_log2), .max_dy(max_dy),
        .out_valid(out_valid), .out_chan(out_chan), .out_sample(out_sample),
        .out_page(out_page), .out_tpl(out_tpl)
    );

    int n_cmp = 0, n_bad = 0, cyc = 0;
    bit started = 0, done = 0;

    // behavioural reference state
    int m_wf [4][2][16];
    int m_mean [4][2];
    int m_ph [4], m_pg [4], m_pr [4], m_tv [4], m_tp [4], m_acc [4], m_sok [4], m_sbad [4];
    int exp_valid, exp_chan, exp_page, exp_tpl, exp_sample;
    int c, y, lgv, len, ph, st, d, bad, tot;

    always @(posedge clk) begin
        started <= 1;
        if (rst) begin
            exp_valid = 0;
            for (int i = 0; i < 4; i++) begin
                m_ph[i] = 0; m_pg[i] = 0; m_pr[i] = 0; m_tv[i] = 0; m_tp[i] = 0;
                m_acc[i] = 0; m_sok[i] = 0; m_sbad[i] = 0;
                m_mean[i][0] = 0; m_mean[i][1] = 0;
            end
        end else begin
            exp_valid = in_valid;
            if (in_valid) begin
                c   = in_chan;
                y   = in_sample;
                lgv = (period_log2 > 4) ? 4 : period_log2;
                len = 1 << lgv;
                ph  = m_ph[c];
                st  = m_wf[c][m_pg[c]][ph];
                d   = y - st;
                if (d < 0) d = -d;
                bad = (d > int'(max_dy)) ? 1 : 0;           // R11 strict
                exp_chan   = c;
                exp_page   = m_pg[c];
                exp_tpl    = m_tv[c];
                exp_sample = m_tv[c] ? y - (m_wf[c][m_tp[c]][ph] - m_mean[c][m_tp[c]]) : y;
                m_wf[c][m_pg[c]][ph] = y;
                tot = m_acc[c] + y;
                if (ph == len - 1) begin
                    if (!m_pr[c]) m_pr[c] = 1;
                    else if (!(m_sbad[c] || bad)) begin
                        m_mean[c][m_pg[c]] = tot >>> lgv;
                        m_tv[c] = 1; m_tp[c] = m_pg[c]; m_pg[c] ^= 1; m_pr[c] = 0;
                    end else if (!(m_sok[c] || !bad)) begin
                        m_tv[c] = 0; m_pg[c] ^= 1; m_pr[c] = 0;
                    end
                    m_ph[c] = 0; m_acc[c] = 0; m_sok[c] = 0; m_sbad[c] = 0;
                end else begin
                    m_ph[c] = ph + 1; m_acc[c] = tot;
                    m_sok[c] = m_sok[c] | !bad; m_sbad[c] = m_sbad[c] | bad;
                end
            end
        end
    end

    always @(negedge clk) begin
        if (started && !done) begin
            n_cmp++;
            if (int'(out_valid) != exp_valid) begin
                n_bad++;
                $display("FAIL R2,R1 out_valid got %0d exp %0d", out_valid, exp_valid);
            end
            if (exp_valid && !rst) begin
                n_cmp++;
                if (int'(out_chan) != exp_chan) begin
                    n_bad++;
                    $display("FAIL R2,R5 out_chan got %0d exp %0d", out_chan, exp_chan);
                end
                n_cmp++;
                if (int'(out_page) != exp_page) begin
                    n_bad++;
                    $display("FAIL R10,R7 out_page got %0d exp %0d", out_page, exp_page);
                end
                n_cmp++;
                if (int'(out_tpl) != exp_tpl) begin
                    n_bad++;
                    $display("FAIL R6,R7,R8,R11 out_tpl got %0d exp %0d", out_tpl, exp_tpl);
                end
                n_cmp++;
                if (int'(out_sample) != exp_sample) begin
                    n_bad++;
                    if (exp_tpl) $display("FAIL R9,R4 out_sample got %0d exp %0d", out_sample, exp_sample);
                    else         $display("FAIL R3 out_sample got %0d exp %0d", out_sample, exp_sample);
                end
            end
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000 && !done) begin
            done = 1;
            n_bad++;
            $display("FAIL watchdog expired");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    task automatic send(input int ch, input int v);
        @(negedge clk);
        in_valid = 1; in_chan = 2'(ch); in_sample = 16'(v);
    endtask

    task automatic idle();
        @(negedge clk);
        in_valid = 0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        in_valid = 0; rst = 1;
        @(negedge clk);
        @(negedge clk);
        rst = 0;
        // R1: reset state leaves no result pending
        @(negedge clk);
        n_cmp++;
        if (out_valid !== 1'b0) begin
            n_bad++;
            $display("FAIL R1 out_valid after reset got %0d exp 0", out_valid);
        end
    endtask

    int base0 [4] = '{100, 300, -50, 150};
    int base2 [4] = '{-200, -180, 40, 0};

    initial begin
        // Pass A: L = 4, tolerance 20, four interleaved channels
        period_log2 = 3'd2; max_dy = 16'd20;
        do_reset();
        for (int p = 0; p < 12; p++) begin
            for (int k = 0; k < 4; k++) begin
                send(0, base0[k] + ((p >= 6 && p < 8) ? 500 : 0) + int'($urandom % 11) - 5);
                send(1, int'($urandom % 16000) - 8000);
                send(2, base2[k] + ((k == 1 && p % 3 == 2) ? 60 : 0));
                if (k % 2 == 0) send(3, 1234);
                if (k == 3) idle();
            end
        end
        // Pass B: period setting above range clamps to 16, tolerance equals the step
        period_log2 = 3'd7; max_dy = 16'd3;
        do_reset();
        for (int p = 0; p < 7; p++) begin
            for (int k = 0; k < 16; k++) begin
                send(0, k * 37 - 200 + ((p % 2) ? 3 : 0) + ((p >= 5) ? 9 : 0));
                if (k % 4 == 0) send(2, -k);
            end
        end
        // Pass C: one-sample period, zero tolerance
        period_log2 = 3'd0; max_dy = 16'd0;
        do_reset();
        for (int i = 0; i < 8; i++) send(1, 7);
        for (int i = 0; i < 4; i++) send(1, 9 + i * 100);
        for (int i = 0; i < 4; i++) send(3, -32768);
        idle();
        idle();
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule